// File: doc/BRIEF.md
# Length-Prefixed Frame Builder and Checker

This block wraps payload bytes into frames for a shared-memory transport link, and checks frames that come back the other way. A frame is a four-byte length word, sent most significant byte first, then the payload bytes. When the protocol version selected for the frame is 3, the payload is followed at once by a four-byte CRC-32 check word. The length word counts only the payload, never the check word.

On the transmit path a command carries the payload length, and the version is sampled when that command is accepted. The framer then sends the header, passes the payload through with the same order and values, and appends the check word if one is due. On the receive path the checker reads the header and forwards the payload. At the end of each frame it reports a single verdict. A header that gives a zero length or a length above a set limit rejects the frame. The checker then throws away input up to the byte marked as the end of the stored frame, and starts parsing again after it.

All data paths are byte-wide valid/ready streams. A stall on an output holds everything where it is, and the running checksum stays intact.

Top module: `lenframe_codec`

## Requirements
- R1: After a command is accepted on `txc_valid`/`txc_ready`, the transmit output first carries four header bytes holding the 32-bit zero-extended payload length, most significant byte first.
- R2: After the header, the transmit output carries exactly length payload bytes, taken from `txi_data` in the same order and unchanged.
- R3: When `tx_ver` equals 3 at command acceptance, the payload is followed at once by four check bytes, most significant byte first. The check word is a CRC-32 over the payload (reflected polynomial 0xEDB88320, each byte taken least significant bit first, remainder starting at 0xFFFFFFFF, final remainder XORed with 0xFFFFFFFF). For the payload "123456789" it is 0xCBF43926.
- R4: For any other `tx_ver` value (1, 2 or 0), no check bytes follow the payload.
- R5: `txo_last` is high on exactly the final byte of each transmitted frame. The cycle after that byte is accepted, `txo_valid` is low.
- R6: While `txo_valid` is high and `txo_ready` is low, `txo_valid`, `txo_data` and `txo_last` hold their values into the next cycle.
- R7: On receive, after four header bytes, the next length bytes appear on `rxo_data` with `rxo_valid`, in order and unchanged. `rxo_last` marks the final payload byte.
- R8: When `rx_ver` equals 3 as the fourth header byte is accepted, the four bytes after the payload are read as a big-endian CRC-32 as in R3. One cycle after the last of them is accepted, `rx_end` pulses for one cycle, with `rx_ok` high exactly when the received and computed values agree.
- R9: For any other `rx_ver`, `rx_end` pulses with `rx_ok` high one cycle after the final payload byte is accepted.
- R10: A header length of zero or above `MAX_LEN` (default 64) pulses `rx_end` with `rx_ok` low and `rx_len_err` high one cycle after the fourth header byte. No payload is forwarded. Input bytes are dropped up to and including the one with `rxi_last` high (or none, if the fourth header byte had it), and the next byte starts a new header.
- R11: After reset `txc_ready` is high, `txo_valid`, `rxo_valid` and `rx_end` are low, and `rxi_ready` is high.
- R12: While payload is being forwarded, `rxi_ready` equals `rxo_ready`. In header, check-word and discard phases `rxi_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_ver | input | 2 | Protocol version for the next transmit frame |
| txc_valid | input | 1 | Transmit command valid |
| txc_ready | output | 1 | Transmit command accepted (framer idle) |
| txc_len | input | LEN_W | Payload length of the commanded frame |
| txi_valid | input | 1 | Transmit payload byte valid |
| txi_ready | output | 1 | Transmit payload byte taken |
| txi_data | input | 8 | Transmit payload byte |
| txo_valid | output | 1 | Framed output byte valid |
| txo_ready | input | 1 | Framed output byte taken |
| txo_data | output | 8 | Framed output byte |
| txo_last | output | 1 | Final byte of the frame |
| rx_ver | input | 2 | Protocol version for the frame being received |
| rxi_valid | input | 1 | Received frame byte valid |
| rxi_ready | output | 1 | Received frame byte taken |
| rxi_data | input | 8 | Received frame byte |
| rxi_last | input | 1 | Marks the end of the stored frame, used to resynchronise |
| rxo_valid | output | 1 | Forwarded payload byte valid |
| rxo_ready | input | 1 | Forwarded payload byte taken |
| rxo_data | output | 8 | Forwarded payload byte |
| rxo_last | output | 1 | Final payload byte |
| rx_end | output | 1 | One-cycle frame verdict strobe |
| rx_ok | output | 1 | Frame good, valid with rx_end |
| rx_len_err | output | 1 | Frame rejected for its length, valid with rx_end |

## Verification
The checker module watches properties that hold on every cycle. It confirms that a stalled framed byte stays frozen and that no output byte follows a final byte in the next cycle. It confirms that receive-side input readiness tracks output readiness while payload is forwarded. It also confirms that the verdict strobe lasts one cycle and that a length rejection always comes with a bad verdict. Only the bench scenarios can show that the header bytes, the payload order and the check-word values are right. The same goes for telling good and corrupted check words apart, the accept/reject boundary at exactly `MAX_LEN`, and clean resynchronisation after a rejected frame.

// File: rtl/lenframe_pkg.sv
package lenframe_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;
    localparam logic [1:0]  VER_WITH_CRC  = 2'd3;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_HDR,
        TX_PAY,
        TX_TRL
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_HDR,
        RX_PAY,
        RX_TRL,
        RX_DRAIN
    } rx_state_e;

    typedef struct packed {
        logic       last;
        logic [7:0] data;
    } beat_t;

    typedef struct packed {
        logic done;
        logic ok;
        logic len_err;
    } verdict_t;

    // one byte into a reflected CRC-32 remainder, low bit first
    function automatic logic [31:0] crc32_step(input logic [31:0] rem, input logic [7:0] b);
        logic [31:0] r;
        r = rem ^ {24'd0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

    // byte of a word in wire order, position 0 is the most significant
    function automatic logic [7:0] wire_byte(input logic [31:0] w, input logic [1:0] pos);
        logic [7:0] r;
        case (pos)
            2'd0:    r = w[31:24];
            2'd1:    r = w[23:16];
            2'd2:    r = w[15:8];
            default: r = w[7:0];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lenframe_crc_acc.sv
module lenframe_crc_acc
    import lenframe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        seed,
    input  logic        step,
    input  logic [7:0]  data,
    output logic [31:0] crc_out
);

    logic [31:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst || seed) begin
            rem_q <= CRC_SEED;
        end else if (step) begin
            rem_q <= crc32_step(rem_q, data);
        end
    end

    assign crc_out = rem_q ^ CRC_SEED;

endmodule

// File: rtl/lenframe_tx.sv
module lenframe_tx
    import lenframe_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       ver,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output beat_t            out_beat
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    tx_state_e        st_q;
    logic [1:0]       pos_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic             crc_on_q;
    logic [31:0]      hdr_word;
    logic [31:0]      crc_fin;
    logic             pay_last;
    logic             pay_take;
    logic             cmd_take;

    assign hdr_word = 32'(len_q);
    assign pay_last = (cnt_q == len_q - ONE);
    assign cmd_take = cmd_valid && (st_q == TX_IDLE);
    assign pay_take = (st_q == TX_PAY) && in_valid && out_ready;

    lenframe_crc_acc u_crc (
        .clk     (clk),
        .rst     (rst),
        .seed    (cmd_take),
        .step    (pay_take),
        .data    (in_data),
        .crc_out (crc_fin)
    );

    always_comb begin
        cmd_ready = (st_q == TX_IDLE);
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_beat  = '0;
        case (st_q)
            TX_HDR: begin
                out_valid     = 1'b1;
                out_beat.data = wire_byte(hdr_word, pos_q);
                out_beat.last = (pos_q == 2'd3) && (len_q == '0) && !crc_on_q;
            end
            TX_PAY: begin
                out_valid     = in_valid;
                in_ready      = out_ready;
                out_beat.data = in_data;
                out_beat.last = pay_last && !crc_on_q;
            end
            TX_TRL: begin
                out_valid     = 1'b1;
                out_beat.data = wire_byte(crc_fin, pos_q);
                out_beat.last = (pos_q == 2'd3);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= TX_IDLE;
            pos_q    <= '0;
            len_q    <= '0;
            cnt_q    <= '0;
            crc_on_q <= 1'b0;
        end else begin
            case (st_q)
                TX_IDLE: begin
                    if (cmd_valid) begin
                        len_q    <= cmd_len;
                        crc_on_q <= (ver == VER_WITH_CRC);
                        pos_q    <= '0;
                        cnt_q    <= '0;
                        st_q     <= TX_HDR;
                    end
                end
                TX_HDR: begin
                    if (out_ready) begin
                        pos_q <= pos_q + 2'd1;
                        if (pos_q == 2'd3) begin
                            if (len_q != '0) st_q <= TX_PAY;
                            else if (crc_on_q) st_q <= TX_TRL;
                            else st_q <= TX_IDLE;
                        end
                    end
                end
                TX_PAY: begin
                    if (pay_take) begin
                        cnt_q <= cnt_q + ONE;
                        if (pay_last) st_q <= crc_on_q ? TX_TRL : TX_IDLE;
                    end
                end
                TX_TRL: begin
                    if (out_ready) begin
                        pos_q <= pos_q + 2'd1;
                        if (pos_q == 2'd3) st_q <= TX_IDLE;
                    end
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lenframe_rx.sv
module lenframe_rx
    import lenframe_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MAX_LEN = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic [1:0] ver,
    input  logic     in_valid,
    output logic     in_ready,
    input  beat_t    in_beat,
    output logic     out_valid,
    input  logic     out_ready,
    output beat_t    out_beat,
    output verdict_t verdict
);

    localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);
    localparam logic [31:0]      LEN_CAP = 32'(MAX_LEN);

    rx_state_e        st_q;
    logic [1:0]       pos_q;
    logic [23:0]      sh_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic             crc_on_q;
    verdict_t         verdict_q;
    logic [31:0]      word_in;
    logic [31:0]      crc_fin;
    logic             take;
    logic             len_bad;
    logic             pay_last;
    logic             hdr_done;
    logic             pay_take;

    assign word_in  = {sh_q, in_beat.data};
    assign len_bad  = (word_in == 32'd0) || (word_in > LEN_CAP);
    assign pay_last = (cnt_q == len_q - ONE);
    assign take     = in_valid && in_ready;
    assign hdr_done = take && (st_q == RX_HDR) && (pos_q == 2'd3);
    assign pay_take = take && (st_q == RX_PAY);

    lenframe_crc_acc u_crc (
        .clk     (clk),
        .rst     (rst),
        .seed    (hdr_done),
        .step    (pay_take),
        .data    (in_beat.data),
        .crc_out (crc_fin)
    );

    always_comb begin
        in_ready      = (st_q == RX_PAY) ? out_ready : 1'b1;
        out_valid     = (st_q == RX_PAY) && in_valid;
        out_beat.data = in_beat.data;
        out_beat.last = (st_q == RX_PAY) && pay_last;
    end

    assign verdict = verdict_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= RX_HDR;
            pos_q     <= '0;
            sh_q      <= '0;
            len_q     <= '0;
            cnt_q     <= '0;
            crc_on_q  <= 1'b0;
            verdict_q <= '0;
        end else begin
            verdict_q <= '0;
            case (st_q)
                RX_HDR: begin
                    if (take) begin
                        sh_q  <= {sh_q[15:0], in_beat.data};
                        pos_q <= pos_q + 2'd1;
                        if (pos_q == 2'd3) begin
                            if (len_bad) begin
                                verdict_q <= '{done: 1'b1, ok: 1'b0, len_err: 1'b1};
                                st_q      <= in_beat.last ? RX_HDR : RX_DRAIN;
                            end else begin
                                len_q    <= word_in[LEN_W-1:0];
                                cnt_q    <= '0;
                                crc_on_q <= (ver == VER_WITH_CRC);
                                st_q     <= RX_PAY;
                            end
                        end
                    end
                end
                RX_PAY: begin
                    if (take) begin
                        cnt_q <= cnt_q + ONE;
                        if (pay_last) begin
                            pos_q <= '0;
                            if (crc_on_q) begin
                                st_q <= RX_TRL;
                            end else begin
                                verdict_q <= '{done: 1'b1, ok: 1'b1, len_err: 1'b0};
                                st_q      <= RX_HDR;
                            end
                        end
                    end
                end
                RX_TRL: begin
                    if (take) begin
                        sh_q  <= {sh_q[15:0], in_beat.data};
                        pos_q <= pos_q + 2'd1;
                        if (pos_q == 2'd3) begin
                            verdict_q <= '{done: 1'b1, ok: (word_in == crc_fin), len_err: 1'b0};
                            st_q      <= RX_HDR;
                        end
                    end
                end
                RX_DRAIN: begin
                    if (take && in_beat.last) begin
                        pos_q <= '0;
                        st_q  <= RX_HDR;
                    end
                end
                default: st_q <= RX_HDR;
            endcase
        end
    end

endmodule

// File: rtl/lenframe_codec.sv
module lenframe_codec
    import lenframe_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MAX_LEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       tx_ver,
    input  logic             txc_valid,
    output logic             txc_ready,
    input  logic [LEN_W-1:0] txc_len,
    input  logic             txi_valid,
    output logic             txi_ready,
    input  logic [7:0]       txi_data,
    output logic             txo_valid,
    input  logic             txo_ready,
    output logic [7:0]       txo_data,
    output logic             txo_last,
    input  logic [1:0]       rx_ver,
    input  logic             rxi_valid,
    output logic             rxi_ready,
    input  logic [7:0]       rxi_data,
    input  logic             rxi_last,
    output logic             rxo_valid,
    input  logic             rxo_ready,
    output logic [7:0]       rxo_data,
    output logic             rxo_last,
    output logic             rx_end,
    output logic             rx_ok,
    output logic             rx_len_err
);

    beat_t    tx_beat;
    beat_t    rx_in_beat;
    beat_t    rx_out_beat;
    verdict_t rx_verdict;

    lenframe_tx #(.LEN_W(LEN_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .ver       (tx_ver),
        .cmd_valid (txc_valid),
        .cmd_ready (txc_ready),
        .cmd_len   (txc_len),
        .in_valid  (txi_valid),
        .in_ready  (txi_ready),
        .in_data   (txi_data),
        .out_valid (txo_valid),
        .out_ready (txo_ready),
        .out_beat  (tx_beat)
    );

    assign txo_data = tx_beat.data;
    assign txo_last = tx_beat.last;

    assign rx_in_beat = '{last: rxi_last, data: rxi_data};

    lenframe_rx #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .ver       (rx_ver),
        .in_valid  (rxi_valid),
        .in_ready  (rxi_ready),
        .in_beat   (rx_in_beat),
        .out_valid (rxo_valid),
        .out_ready (rxo_ready),
        .out_beat  (rx_out_beat),
        .verdict   (rx_verdict)
    );

    assign rxo_data   = rx_out_beat.data;
    assign rxo_last   = rx_out_beat.last;
    assign rx_end     = rx_verdict.done;
    assign rx_ok      = rx_verdict.ok;
    assign rx_len_err = rx_verdict.len_err;

endmodule

// File: rtl/lenframe_codec_chk.sv
module lenframe_codec_chk (
    input logic       clk,
    input logic       rst,
    input logic       txc_ready,
    input logic       txo_valid,
    input logic       txo_ready,
    input logic [7:0] txo_data,
    input logic       txo_last,
    input logic       rxi_valid,
    input logic       rxi_ready,
    input logic       rxo_valid,
    input logic       rxo_ready,
    input logic       rxo_last,
    input logic       rx_end,
    input logic       rx_ok,
    input logic       rx_len_err
);

    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (txo_valid && !txo_ready) |=> (txo_valid && $stable(txo_data) && $stable(txo_last)));

    assert_tx_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (txo_valid && txo_ready && txo_last) |=> !txo_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        txc_ready |-> !txo_valid);

    assert_rx_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (rxo_valid && rxo_ready && rxo_last) |=> !rxo_valid);

    assert_rx_ready_R12: assert property (@(posedge clk) disable iff (rst)
        rxo_valid |-> (rxi_valid && (rxi_ready == rxo_ready)));

    assert_end_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rx_end |=> !rx_end);

    assert_len_reject_R10: assert property (@(posedge clk) disable iff (rst)
        rx_len_err |-> (rx_end && !rx_ok));

endmodule

bind lenframe_codec lenframe_codec_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .txc_ready  (txc_ready),
    .txo_valid  (txo_valid),
    .txo_ready  (txo_ready),
    .txo_data   (txo_data),
    .txo_last   (txo_last),
    .rxi_valid  (rxi_valid),
    .rxi_ready  (rxi_ready),
    .rxo_valid  (rxo_valid),
    .rxo_ready  (rxo_ready),
    .rxo_last   (rxo_last),
    .rx_end     (rx_end),
    .rx_ok      (rx_ok),
    .rx_len_err (rx_len_err)
);

// File: tb/sim_lenframe_codec.sv
`timescale 1ns/1ps
module sim_lenframe_codec;

    localparam int LEN_W   = 16;
    localparam int MAX_LEN = 64;

    typedef logic [7:0] bytes_t[$];

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] tx_ver = 2'd1;
    logic txc_valid = 1'b0;
    logic txc_ready;
    logic [LEN_W-1:0] txc_len = '0;
    logic txi_valid = 1'b0;
    logic txi_ready;
    logic [7:0] txi_data = '0;
    logic txo_valid;
    logic txo_ready = 1'b1;
    logic [7:0] txo_data;
    logic txo_last;
    logic [1:0] rx_ver = 2'd1;
    logic rxi_valid = 1'b0;
    logic rxi_ready;
    logic [7:0] rxi_data = '0;
    logic rxi_last = 1'b0;
    logic rxo_valid;
    logic rxo_ready = 1'b1;
    logic [7:0] rxo_data;
    logic rxo_last;
    logic rx_end;
    logic rx_ok;
    logic rx_len_err;

    int ntot = 0;
    int nbad = 0;
    int cyc  = 0;

    // tx item: {kind[1:0], last, data}; kind 0 header, 1 payload, 2 trailer
    logic [10:0] txq[$];
    // rx payload item: {last, data}
    logic [8:0]  rxpq[$];
    // rx verdict item: {crc_mode, ok, len_err}
    logic [2:0]  rxeq[$];

    always #5 clk = ~clk;

    lenframe_codec #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u0 (.*);

    task automatic check(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
        ntot++;
        if (!good) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ref_crc(input bytes_t d);
        logic [31:0] c;
        logic [31:0] r;
        logic fb;
        c = 32'hFFFFFFFF;
        foreach (d[k]) begin
            for (int b = 0; b < 8; b++) begin
                fb = c[31] ^ d[k][b];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C11DB7;
            end
        end
        for (int b = 0; b < 32; b++) r[b] = c[31-b];
        return r ^ 32'hFFFFFFFF;
    endfunction

    function automatic bytes_t mk(input int n, input int s);
        bytes_t q;
        for (int i = 0; i < n; i++) q.push_back(8'((i * 37 + s * 11 + (i >> 3)) & 255));
        return q;
    endfunction

    function automatic bytes_t digits();
        bytes_t q;
        for (int i = 0; i < 9; i++) q.push_back(8'(8'h31 + i));
        return q;
    endfunction

    // backpressure patterns on both outputs
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            txo_ready = !((cyc % 7 == 3) || (cyc % 7 == 4));
            rxo_ready = (cyc % 5 != 1);
        end
    end

    // tx monitor
    logic       t_prev_stall = 1'b0;
    logic [8:0] t_prev = '0;
    initial begin
        logic [10:0] e;
        forever begin
            @(negedge clk); #4;
            if (!rst) begin
                if (t_prev_stall) begin
                    check(txo_valid && {txo_last, txo_data} == t_prev, "R6 stalled byte held",
                          {23'd0, txo_last, txo_data}, {23'd0, t_prev});
                end
                t_prev_stall = txo_valid && !txo_ready;
                t_prev = {txo_last, txo_data};
                if (txo_valid && txo_ready) begin
                    if (txq.size() == 0) begin
                        check(1'b0, "R2 unexpected tx byte", {24'd0, txo_data}, 32'd0);
                    end else begin
                        e = txq.pop_front();
                        case (e[10:9])
                            2'd0: check(txo_data == e[7:0], "R1 header byte", {24'd0, txo_data}, {24'd0, e[7:0]});
                            2'd1: check(txo_data == e[7:0], "R2 payload byte", {24'd0, txo_data}, {24'd0, e[7:0]});
                            default: check(txo_data == e[7:0], "R3 crc byte", {24'd0, txo_data}, {24'd0, e[7:0]});
                        endcase
                        check(txo_last == e[8], "R5 R4 last flag", {31'd0, txo_last}, {31'd0, e[8]});
                    end
                end
            end
        end
    end

    // rx monitor
    initial begin
        logic [8:0] p;
        logic [2:0] v;
        forever begin
            @(negedge clk); #4;
            if (!rst) begin
                if (rxo_valid) begin
                    check(rxi_ready == rxo_ready, "R12 input ready follows output ready",
                          {31'd0, rxi_ready}, {31'd0, rxo_ready});
                end
                if (rxo_valid && rxo_ready) begin
                    if (rxpq.size() == 0) begin
                        check(1'b0, "R10 R7 unexpected payload byte", {24'd0, rxo_data}, 32'd0);
                    end else begin
                        p = rxpq.pop_front();
                        check({rxo_last, rxo_data} == p, "R7 forwarded payload",
                              {23'd0, rxo_last, rxo_data}, {23'd0, p});
                    end
                end
                if (rx_end) begin
                    if (rxeq.size() == 0) begin
                        check(1'b0, "R8 unexpected verdict", {30'd0, rx_ok, rx_len_err}, 32'd0);
                    end else begin
                        v = rxeq.pop_front();
                        if (v[0])
                            check({rx_ok, rx_len_err} == v[1:0], "R10 length reject verdict",
                                  {30'd0, rx_ok, rx_len_err}, {30'd0, v[1:0]});
                        else if (v[2])
                            check({rx_ok, rx_len_err} == v[1:0], "R8 crc verdict",
                                  {30'd0, rx_ok, rx_len_err}, {30'd0, v[1:0]});
                        else
                            check({rx_ok, rx_len_err} == v[1:0], "R9 no-crc verdict",
                                  {30'd0, rx_ok, rx_len_err}, {30'd0, v[1:0]});
                    end
                end
            end
        end
    end

    task automatic tx_frame(input bytes_t pl, input logic [1:0] ver);
        int n;
        logic [31:0] c;
        n = pl.size();
        for (int i = 0; i < 4; i++)
            txq.push_back({2'd0, (i == 3 && n == 0 && ver != 2'd3), 8'(n >> (8 * (3 - i)))});
        for (int i = 0; i < n; i++)
            txq.push_back({2'd1, (i == n - 1 && ver != 2'd3), pl[i]});
        if (ver == 2'd3) begin
            c = ref_crc(pl);
            for (int i = 0; i < 4; i++) txq.push_back({2'd2, (i == 3), 8'(c >> (8 * (3 - i)))});
        end
        @(negedge clk);
        tx_ver = ver;
        txc_len = LEN_W'(n);
        txc_valid = 1'b1;
        #4;
        while (!txc_ready) begin @(negedge clk); #4; end
        @(negedge clk);
        txc_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            txi_valid = 1'b1;
            txi_data = pl[i];
            #4;
            while (!txi_ready) begin @(negedge clk); #4; end
            @(negedge clk);
        end
        txi_valid = 1'b0;
    endtask

    // hdr_len < 0: use payload size; junk: discarded bytes after a bad header
    task automatic rx_frame(input bytes_t pl, input logic [1:0] ver, input bit bad_crc,
                            input int hdr_len, input int junk);
        bytes_t s;
        int n;
        int hl;
        logic [31:0] c;
        bit rej;
        n = pl.size();
        hl = (hdr_len < 0) ? n : hdr_len;
        rej = (hl == 0) || (hl > MAX_LEN);
        for (int i = 0; i < 4; i++) s.push_back(8'(hl >> (8 * (3 - i))));
        if (rej) begin
            for (int i = 0; i < junk; i++) s.push_back(8'(8'hA0 + i));
            rxeq.push_back(3'b001);
        end else begin
            foreach (pl[i]) begin
                s.push_back(pl[i]);
                rxpq.push_back({(i == n - 1), pl[i]});
            end
            if (ver == 2'd3) begin
                c = ref_crc(pl) ^ (bad_crc ? 32'h0000_0100 : 32'h0);
                for (int i = 0; i < 4; i++) s.push_back(8'(c >> (8 * (3 - i))));
                rxeq.push_back({1'b1, !bad_crc, 1'b0});
            end else begin
                rxeq.push_back(3'b010);
            end
        end
        @(negedge clk);
        rx_ver = ver;
        for (int i = 0; i < s.size(); i++) begin
            rxi_valid = 1'b1;
            rxi_data = s[i];
            rxi_last = (i == s.size() - 1);
            #4;
            while (!rxi_ready) begin @(negedge clk); #4; end
            @(negedge clk);
        end
        rxi_valid = 1'b0;
        rxi_last = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", ntot, nbad);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        ntot++;
        nbad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #4;
        // R11 reset state
        check(txc_ready == 1'b1, "R11 txc_ready after reset", {31'd0, txc_ready}, 32'd1);
        check(txo_valid == 1'b0, "R11 txo_valid after reset", {31'd0, txo_valid}, 32'd0);
        check(rxo_valid == 1'b0, "R11 rxo_valid after reset", {31'd0, rxo_valid}, 32'd0);
        check(rx_end == 1'b0, "R11 rx_end after reset", {31'd0, rx_end}, 32'd0);
        check(rxi_ready == 1'b1, "R11 rxi_ready after reset", {31'd0, rxi_ready}, 32'd1);
        // R3 known check value
        check(ref_crc(digits()) == 32'hCBF43926, "R3 reference check value",
              ref_crc(digits()), 32'hCBF43926);
        fork
            begin
                tx_frame(digits(), 2'd3);
                tx_frame(mk(5, 1), 2'd1);
                tx_frame(mk(1, 2), 2'd2);
                tx_frame(mk(20, 3), 2'd3);
                tx_frame(mk(3, 4), 2'd0);
                tx_frame(mk(2, 5), 2'd3);
            end
            begin
                rx_frame(digits(), 2'd3, 1'b0, -1, 0);
                rx_frame(digits(), 2'd3, 1'b1, -1, 0);
                rx_frame(mk(3, 6), 2'd1, 1'b0, -1, 0);
                rx_frame(mk(1, 7), 2'd1, 1'b0, 0, 2);
                rx_frame(mk(64, 8), 2'd2, 1'b0, -1, 0);
                rx_frame(mk(1, 9), 2'd2, 1'b0, 65, 3);
                rx_frame(mk(1, 9), 2'd3, 1'b0, 0, 0);
                rx_frame(mk(4, 10), 2'd3, 1'b0, -1, 0);
            end
        join
        repeat (30) @(negedge clk);
        check(txq.size() == 0, "R2 all tx bytes emitted", txq.size(), 32'd0);
        check(rxpq.size() == 0, "R7 all payload forwarded", rxpq.size(), 32'd0);
        check(rxeq.size() == 0, "R9 all verdicts seen", rxeq.size(), 32'd0);
        summary();
        $finish;
    end

endmodule